// File: doc/BRIEF.md
# Excluded-Tag Random Tag Generator

This block picks a 4-bit allocation tag for a 64-bit pointer and returns the pointer with that tag placed in its tag field. A random request starts from the tag held in an internal state register. It draws a 4-bit step count from four shifts of a 16-bit linear feedback shift register, which is also held in that register. It then walks forward over tag values, skipping every value that is excluded, and wraps modulo 16. A tag value is excluded when its bit is set in the request's mask or in the shared control mask. After an accepted random request, the chosen tag and the advanced seed are written back to the state register.

The same walking logic serves an add/subtract-with-tag request. That request starts from the tag already in the pointer, uses a step count given by the caller, skips only values in the control mask, and adds a signed byte offset to the address. Software can load the state register directly through a plain write port and can read it at any time.

Requests and results move over one valid/ready stream with no latency. The result is valid in the same cycle as the request, and `in_ready` follows `out_ready`. The consumer can stall the stream by holding `out_ready` low. While a request waits, the result stays a function of the held inputs, and the state register does not move.

Top module: `tag_gen`

## Requirements
- R1: For a random request the excluded set is `in_excl | ctrl_excl`; bit n set forbids tag n, and a result tag is never a forbidden value unless all 16 are forbidden.
- R2: When every tag value is forbidden (mask 0xFFFF) the result tag is 0, for both request kinds.
- R3: One LFSR shift computes fb = s[5]^s[3]^s[2]^s[0], shifts s right by one and places fb in bit 15; an accepted random request advances the stored seed by exactly four shifts.
- R4: The feedback bit of shift i (i = 0..3) becomes bit i of the step count; from state tag 0, seed 0x0001 and no exclusions, the result tag is 1 and the state becomes 0x100001.
- R5: With step count 0 the start tag is kept if it is allowed, otherwise the first allowed value above it (mod 16) is taken.
- R6: With step count k > 0 the tag moves to the next allowed value (mod 16) k times.
- R7: The state register `st_q` holds the tag in [3:0] and the seed in [23:8], with [7:4] reading 0; after an accepted random request it holds the result tag and the advanced seed.
- R8: An add/subtract request (`in_op` = 1; `in_op` = 0 is random) starts from `in_ptr[59:56]`, steps `in_tag_ofs` times over the control mask only, adds the sign-extended `in_byte_ofs` to the address, and leaves `st_q` unchanged.
- R9: The result tag is placed in `out_ptr[59:56]` and equals `out_tag`; for a random request all other bits equal `in_ptr`.
- R10: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `st_q` changes only when a request is accepted (`in_valid && out_ready`) or written.
- R11: A state write (`st_wr_en`) in the same cycle as an accepted random request wins: `st_q` takes the written tag and seed fields.
- R12: After reset `st_q` holds tag 0 and seed 0x0001 (0x000100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_excl | input | 16 | Shared exclusion mask, bit n forbids tag n |
| st_wr_en | input | 1 | Load the state register from st_wr_data |
| st_wr_data | input | 24 | State to load: tag [3:0], seed [23:8] |
| st_q | output | 24 | Current state: tag [3:0], seed [23:8] |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_op | input | 1 | 0 random tag, 1 add/subtract with tag |
| in_ptr | input | 64 | Pointer to be tagged |
| in_excl | input | 16 | Request exclusion mask (random only) |
| in_tag_ofs | input | 4 | Tag step count (add/subtract only) |
| in_byte_ofs | input | 16 | Signed byte offset (add/subtract only) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_ptr | output | 64 | Pointer carrying the chosen tag |
| out_tag | output | 4 | Chosen tag |

## Verification
The state register has two writers that can act in the same cycle: a software load through `st_wr_en` and the write-back of an accepted random request. The bench provokes the clash on purpose, and also mixes random loads into a long run with random valid and ready. It judges the result by reading `st_q` one cycle later against a reference model in which the load takes priority. The same model checks that stalled or add/subtract requests leave `st_q` untouched in those cycles.

// File: rtl/tag_gen_pkg.sv
package tag_gen_pkg;
  typedef enum logic {
    OP_RAND   = 1'b0,
    OP_ADDSUB = 1'b1
  } tag_op_e;
endpackage

// File: rtl/tag_lfsr_walk.sv
module tag_lfsr_walk #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [STEPS-1:0]  ofs_o
);
  logic [SEED_W-1:0] chain [0:STEPS];

  assign chain[0] = seed_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_shift
    logic fb;
    assign fb           = chain[g][5] ^ chain[g][3] ^ chain[g][2] ^ chain[g][0];
    assign chain[g+1]   = {fb, chain[g][SEED_W-1:1]};
    assign ofs_o[g]     = fb;
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/tag_pick.sv
module tag_pick #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0]         start_i,
  input  logic [TAG_W-1:0]         ofs_i,
  input  logic [(1<<TAG_W)-1:0]    excl_i,
  output logic [TAG_W-1:0]         tag_o
);
  localparam int NT = 1 << TAG_W;

  function automatic logic [TAG_W-1:0] next_free(input logic [TAG_W-1:0] t,
                                                  input logic [NT-1:0] ex);
    logic [TAG_W-1:0] r;
    logic [TAG_W-1:0] cand;
    logic             hit;
    r   = t;
    hit = 1'b0;
    for (int d = 1; d <= NT; d++) begin
      cand = t + TAG_W'(d);
      if (!hit && !ex[cand]) begin
        r   = cand;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [TAG_W-1:0] walk;

  always_comb begin
    walk = start_i;
    if (ofs_i == '0) begin
      if (excl_i[start_i]) walk = next_free(start_i, excl_i);
    end else begin
      for (int i = 1; i < NT; i++) begin
        if (i <= int'(ofs_i)) walk = next_free(walk, excl_i);
      end
    end
    tag_o = (&excl_i) ? '0 : walk;
  end
endmodule

// File: rtl/tag_gen.sv
module tag_gen #(
  parameter int ADDR_W     = 64,
  parameter int TAG_W      = 4,
  parameter int TAG_LSB    = 56,
  parameter int SEED_W     = 16,
  parameter int SEED_LSB   = 8,
  parameter int BOFS_W     = 16,
  parameter logic [15:0] RESET_SEED = 16'h0001
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [(1<<TAG_W)-1:0]          ctrl_excl,
  input  logic                           st_wr_en,
  input  logic [SEED_LSB+SEED_W-1:0]     st_wr_data,
  output logic [SEED_LSB+SEED_W-1:0]     st_q,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_op,
  input  logic [ADDR_W-1:0]              in_ptr,
  input  logic [(1<<TAG_W)-1:0]          in_excl,
  input  logic [TAG_W-1:0]               in_tag_ofs,
  input  logic [BOFS_W-1:0]              in_byte_ofs,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [ADDR_W-1:0]              out_ptr,
  output logic [TAG_W-1:0]               out_tag
);
  import tag_gen_pkg::*;

  localparam int NT   = 1 << TAG_W;
  localparam int ST_W = SEED_LSB + SEED_W;
  localparam int GAP  = SEED_LSB - TAG_W;

  tag_op_e           op;
  logic              is_add;
  logic              fire;
  logic [TAG_W-1:0]  st_tag;
  logic [SEED_W-1:0] st_seed;
  logic [SEED_W-1:0] seed_nx;
  logic [TAG_W-1:0]  rnd_ofs;
  logic [TAG_W-1:0]  start;
  logic [TAG_W-1:0]  step;
  logic [NT-1:0]     excl;
  logic [TAG_W-1:0]  new_tag;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] bofs_ext;

  assign op      = tag_op_e'(in_op);
  assign is_add  = (op == OP_ADDSUB);
  assign st_tag  = st_q[TAG_W-1:0];
  assign st_seed = st_q[SEED_LSB +: SEED_W];

  tag_lfsr_walk #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_walk (
    .seed_i (st_seed),
    .seed_o (seed_nx),
    .ofs_o  (rnd_ofs)
  );

  assign start = is_add ? in_ptr[TAG_LSB +: TAG_W] : st_tag;
  assign step  = is_add ? in_tag_ofs : rnd_ofs;
  assign excl  = is_add ? ctrl_excl : (ctrl_excl | in_excl);

  tag_pick #(.TAG_W(TAG_W)) u_pick (
    .start_i (start),
    .ofs_i   (step),
    .excl_i  (excl),
    .tag_o   (new_tag)
  );

  assign bofs_ext = {{(ADDR_W-BOFS_W){in_byte_ofs[BOFS_W-1]}}, in_byte_ofs};
  assign base     = is_add ? (in_ptr + bofs_ext) : in_ptr;

  always_comb begin
    out_ptr                     = base;
    out_ptr[TAG_LSB +: TAG_W]   = new_tag;
  end

  assign out_tag   = new_tag;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign fire      = in_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= {RESET_SEED[SEED_W-1:0], {GAP{1'b0}}, {TAG_W{1'b0}}};
    end else if (st_wr_en) begin
      st_q <= {st_wr_data[SEED_LSB +: SEED_W], {GAP{1'b0}}, st_wr_data[TAG_W-1:0]};
    end else if (fire && !is_add) begin
      st_q <= {seed_nx, {GAP{1'b0}}, new_tag};
    end
  end
endmodule

// File: rtl/tag_gen_checker.sv
module tag_gen_checker #(
  parameter int ADDR_W   = 64,
  parameter int TAG_W    = 4,
  parameter int TAG_LSB  = 56,
  parameter int SEED_W   = 16,
  parameter int SEED_LSB = 8,
  parameter int BOFS_W   = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [(1<<TAG_W)-1:0]       ctrl_excl,
  input logic                        st_wr_en,
  input logic [SEED_LSB+SEED_W-1:0]  st_wr_data,
  input logic [SEED_LSB+SEED_W-1:0]  st_q,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        in_op,
  input logic [ADDR_W-1:0]           in_ptr,
  input logic [(1<<TAG_W)-1:0]       in_excl,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [ADDR_W-1:0]           out_ptr,
  input logic [TAG_W-1:0]            out_tag
);
  logic [(1<<TAG_W)-1:0] rnd_mask;
  assign rnd_mask = in_excl | ctrl_excl;

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_op && !(&rnd_mask)) |-> !rnd_mask[out_tag]);

  p_allones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (in_op ? (&ctrl_excl) : (&rnd_mask))) |-> (out_tag == '0));

  p_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ptr[TAG_LSB +: TAG_W] == out_tag));

  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_op) |-> ((out_ptr ^ in_ptr) >> TAG_LSB >> TAG_W) == '0
                              && out_ptr[TAG_LSB-1:0] == in_ptr[TAG_LSB-1:0]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && out_ready) && !st_wr_en) |=> $stable(st_q));

  p_addsub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && in_op && !st_wr_en) |=> $stable(st_q));

  p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && !in_op && !st_wr_en) |=> (st_q[TAG_W-1:0] == $past(out_tag)));

  p_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> (st_q[TAG_W-1:0] == $past(st_wr_data[TAG_W-1:0]))
              && (st_q[SEED_LSB +: SEED_W] == $past(st_wr_data[SEED_LSB +: SEED_W])));

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[SEED_LSB-1:TAG_W] == '0);
endmodule

bind tag_gen tag_gen_checker #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB),
  .SEED_W(SEED_W), .SEED_LSB(SEED_LSB), .BOFS_W(BOFS_W)
) u_chk (.*);

// File: tb/tag_gen_bench.sv
`timescale 1ns/1ps
module tag_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_excl = '0;
  logic        st_wr_en = 1'b0;
  logic [23:0] st_wr_data = '0;
  logic [23:0] st_q;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_op = 1'b0;
  logic [63:0] in_ptr = '0;
  logic [15:0] in_excl = '0;
  logic [3:0]  in_tag_ofs = '0;
  logic [15:0] in_byte_ofs = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_ptr;
  logic [3:0]  out_tag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  int m_st   = 32'h000100;

  always #2.5 clk = ~clk;

  tag_gen u_tag_gen (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int choose(input int t, input int off, input int ex);
    if ((ex & 16'hffff) == 16'hffff) return 0;
    if (off == 0) begin
      while ((ex >> t) & 1) t = (t + 1) % 16;
    end else begin
      repeat (off) begin
        t = (t + 1) % 16;
        while ((ex >> t) & 1) t = (t + 1) % 16;
      end
    end
    return t;
  endfunction

  task automatic cyc(input string req, input bit v, input bit r, input bit op,
                     input logic [63:0] p, input logic [15:0] ex,
                     input logic [3:0] tofs, input logic [15:0] bofs,
                     input bit we, input logic [23:0] wd);
    int s, off, fb, tag, ex_all;
    logic [63:0] addr;
    @(negedge clk);
    in_valid = v; out_ready = r; in_op = op; in_ptr = p; in_excl = ex;
    in_tag_ofs = tofs; in_byte_ofs = bofs; st_wr_en = we; st_wr_data = wd;
    #1;
    s = (m_st >> 8) & 16'hffff;
    off = 0;
    for (int i = 0; i < 4; i++) begin
      fb  = ((s >> 5) ^ (s >> 3) ^ (s >> 2) ^ s) & 1;
      s   = (s >> 1) | (fb << 15);
      off = off | (fb << i);
    end
    if (op) begin
      tag  = choose(int'(p[59:56]), int'(tofs), int'(ctrl_excl));
      addr = p + {{48{bofs[15]}}, bofs};
    end else begin
      ex_all = int'(ex | ctrl_excl);
      tag  = choose(m_st & 15, off, ex_all);
      addr = p;
    end
    addr[59:56] = tag[3:0];
    chk({req, " valid"}, 64'(out_valid), 64'(v));
    chk({req, " ready"}, 64'(in_ready), 64'(r));
    if (v) begin
      chk({req, " tag"}, 64'(out_tag), 64'(tag));
      chk({req, " ptr"}, out_ptr, addr);
    end
    if (we) m_st = (int'(wd) & 32'hffff00) | (int'(wd) & 15);
    else if (v && r && !op) m_st = (s << 8) | tag;
    @(posedge clk);
    #1;
    chk({req, " state"}, 64'(st_q), 64'(m_st));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 reset state", 64'(st_q), 64'h000100);

    // R4: seed 0x0001, tag 0, no exclusions -> tag 1, state 0x100001
    cyc("R4 offset bits", 1, 1, 0, 64'h0123_4567_89ab_cdef, 16'h0, 0, 0, 0, 0);
    chk("R4 state literal", 64'(st_q), 64'h100001);
    chk("R4 tag literal", 64'(out_tag), 64'h1);

    // R3: random seeds advance by four shifts
    cyc("R3 load", 0, 0, 0, 0, 0, 0, 0, 1, 24'hACE1_05);
    cyc("R3 advance", 1, 1, 0, 64'h0, 16'h0, 0, 0, 0, 0);
    cyc("R3 advance again", 1, 1, 0, 64'h0, 16'h0, 0, 0, 0, 0);

    // R5: seed 0 gives offset 0; start 5 with 5,6 excluded -> 7
    cyc("R5 load", 0, 0, 0, 0, 0, 0, 0, 1, 24'h0000_05);
    cyc("R5 skip", 1, 1, 0, 64'h0, 16'h0060, 0, 0, 0, 0);
    chk("R5 tag literal", 64'(st_q[3:0]), 64'h7);
    cyc("R5 keep", 1, 1, 0, 64'h0, 16'h0001, 0, 0, 0, 0);

    // R2: all excluded
    cyc("R2 random all ones", 1, 1, 0, 64'hffff_ffff_ffff_ffff, 16'hffff, 0, 0, 0, 0);
    ctrl_excl = 16'hffff;
    cyc("R2 addsub all ones", 1, 1, 1, 64'h0e00_0000_0000_1000, 0, 4'd3, 16'h0010, 0, 0);
    ctrl_excl = 16'h8001;

    // R6/R8: tag 14, step 3, 15 and 0 excluded -> 3; negative byte offset
    cyc("R6 R8 addsub", 1, 1, 1, 64'h0e00_0000_0000_0008, 16'hffff, 4'd3, 16'hfff0, 0, 0);
    chk("R6 tag literal", 64'(out_tag), 64'h3);
    cyc("R8 carry", 1, 1, 1, 64'h00ff_ffff_ffff_fff0, 0, 4'd0, 16'h0020, 0, 0);

    // R1: union of masks
    ctrl_excl = 16'h0f00;
    cyc("R1 load", 0, 0, 0, 0, 0, 0, 0, 1, 24'h1234_08);
    for (int k = 0; k < 8; k++)
      cyc("R1 union", 1, 1, 0, 64'h0, 16'h00f0, 0, 0, 0, 0);

    // R9: all-ones pointer
    cyc("R9 insert", 1, 1, 0, 64'hffff_ffff_ffff_ffff, 16'h0, 0, 0, 0, 0);

    // R10: stall and idle leave state alone
    cyc("R10 stall", 1, 0, 0, 64'h0, 16'h0, 0, 0, 0, 0);
    cyc("R10 idle", 0, 1, 0, 64'h0, 16'h0, 0, 0, 0, 0);

    // R11: write collides with accepted random request
    cyc("R11 collide", 1, 1, 0, 64'h0, 16'h0, 0, 0, 1, 24'hBEEF_F3);

    // R7: long mixed run
    ctrl_excl = 16'h0;
    for (int k = 0; k < 400; k++) begin
      rp = {$urandom, $urandom};
      cyc("R7 R3 R1 R11 mixed", bit'($urandom % 4 != 0), bit'($urandom % 3 != 0),
          bit'($urandom % 3 == 0), rp, 16'($urandom & $urandom),
          4'($urandom), 16'($urandom), bit'($urandom % 10 == 0), 24'($urandom));
      if (k % 50 == 0) ctrl_excl = 16'($urandom & $urandom & $urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule